// File: doc/BRIEF.md
# Dual-bus ready synchronizer

This block merges the ready indications of two system buses into one synchronized ready signal for a processor. Each bus supplies an active-high ready and an active-low address-enable. A bus's ready counts only while that bus's enable is low. The two qualified readies are ORed and then passed through one or two synchronizing flops before they reach the processor.

Everything runs on a single fast base clock. The slower processor clock is represented by two single-cycle strobes from the clock generator: one marks the processor clock's rising edge and the other marks its falling edge. A per-cycle mode input chooses how an asserting ready is handled:

- **Two-stage mode:** an asserting ready is captured on a rising-edge strobe and only reaches the output at the following falling-edge strobe. This mode is for devices that cannot guarantee setup time.
- **Single-stage mode:** the qualified ready is captured directly at the falling-edge strobe.

In both modes a deasserting ready reaches the output at the next falling-edge strobe.

Top module: `dual_ready_sync`

## Requirements
- R1: While `rst_n` is low, `ready` is 0 and both internal stages hold 0.
- R2: The qualified ready is 1 when `bus_a_rdy`=1 with `bus_a_en_n`=0, or when `bus_b_rdy`=1 with `bus_b_en_n`=0. A ready whose enable is 1 has no effect on `ready`.
- R3: With `one_stage`=0, `ready` rises only at a falling-edge strobe and only if the qualified ready was 1 at the preceding rising-edge strobe and is still 1 at that falling-edge strobe.
- R4: With `one_stage`=0, a qualified ready of 0 at a falling-edge strobe makes `ready` 0 on the next cycle, whatever stage one holds.
- R5: With `one_stage`=1, `ready` takes the qualified ready value at each falling-edge strobe, one base-clock cycle later.
- R6: `ready` changes only in the cycle after a falling-edge strobe.
- R7: `one_stage` is sampled at each falling-edge strobe, so the mode may change between any two processor cycles.
- R8: Stage one updates only at a rising-edge strobe. In two-stage mode, a qualified ready that is asserted after a rising-edge strobe and removed before the next one never raises `ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_rise_stb | input | 1 | One-cycle strobe marking a processor clock rising edge |
| clk_fall_stb | input | 1 | One-cycle strobe marking a processor clock falling edge |
| bus_a_rdy | input | 1 | Bus A ready, active high |
| bus_a_en_n | input | 1 | Bus A address-enable, active low, qualifies `bus_a_rdy` |
| bus_b_rdy | input | 1 | Bus B ready, active high |
| bus_b_en_n | input | 1 | Bus B address-enable, active low, qualifies `bus_b_rdy` |
| one_stage | input | 1 | 1 selects single-stage, 0 selects two-stage synchronization |
| ready | output | 1 | Synchronized ready to the processor |

## Verification
The hardest case to reach is a qualified ready that is present at a falling-edge strobe while stage one still holds a stale value. Examples are a pulse that arrives just after a rising-edge strobe, or a mode switch in the middle of a processor cycle. The bench tracks the strobe phase and places input changes on chosen phases to set up these cases. It then runs a long random phase over every enable combination in both modes, comparing against a behavioural model on every cycle.

// File: rtl/dual_ready_sync.sv
module dual_ready_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_rise_stb,
  input  logic clk_fall_stb,
  input  logic bus_a_rdy,
  input  logic bus_a_en_n,
  input  logic bus_b_rdy,
  input  logic bus_b_en_n,
  input  logic one_stage,
  output logic ready
);

  logic qual;
  logic stage1;
  logic stage2;
  logic stage2_d;

  assign qual = (bus_a_rdy & ~bus_a_en_n) | (bus_b_rdy & ~bus_b_en_n);

  assign stage2_d = one_stage ? qual : (stage1 & qual);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      stage1 <= 1'b0;
    else if (clk_rise_stb)
      stage1 <= qual;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      stage2 <= 1'b0;
    else if (clk_fall_stb)
      stage2 <= stage2_d;
  end

  assign ready = stage2;

endmodule

// File: rtl/dual_ready_sync_chk.sv
module dual_ready_sync_chk (
  input logic clk,
  input logic rst_n,
  input logic clk_rise_stb,
  input logic clk_fall_stb,
  input logic bus_a_rdy,
  input logic bus_a_en_n,
  input logic bus_b_rdy,
  input logic bus_b_en_n,
  input logic one_stage,
  input logic stage1,
  input logic ready
);

  logic port_q;
  assign port_q = (bus_a_rdy && !bus_a_en_n) || (bus_b_rdy && !bus_b_en_n);

  assert_reset_low_R1: assert property (@(posedge clk) !rst_n |-> (!ready && !stage1));

  assert_two_stage_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_fall_stb && !one_stage && !stage1) |=> !ready);

  assert_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_fall_stb && !port_q) |=> !ready);

  assert_single_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_fall_stb && one_stage) |=> (ready == $past(port_q)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_fall_stb |=> $stable(ready));

  assert_stage1_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_rise_stb |=> $stable(stage1));

endmodule

bind dual_ready_sync dual_ready_sync_chk u_chk (.*);

// File: tb/test_dual_ready_sync.sv
module test_dual_ready_sync;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rise_stb = 1'b0;
  logic fall_stb = 1'b0;
  logic a_rdy = 1'b0, a_en_n = 1'b1, b_rdy = 1'b0, b_en_n = 1'b1;
  logic mode1 = 1'b1;
  logic ready;

  int checks = 0;
  int fails = 0;
  int ph = 0;
  bit done = 0;
  bit m_s1 = 0, m_out = 0;

  always #4 clk = ~clk;

  dual_ready_sync i_dual_ready_sync (
    .clk(clk), .rst_n(rst_n), .clk_rise_stb(rise_stb), .clk_fall_stb(fall_stb),
    .bus_a_rdy(a_rdy), .bus_a_en_n(a_en_n), .bus_b_rdy(b_rdy), .bus_b_en_n(b_en_n),
    .one_stage(mode1), .ready(ready)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0;
      m_out = 0;
    end else begin
      bit any;
      bit nxt1;
      bit nxt_out;
      any = 0;
      if (a_rdy === 1'b1 && a_en_n === 1'b0) any = 1;
      if (b_rdy === 1'b1 && b_en_n === 1'b0) any = 1;
      nxt1 = rise_stb ? any : m_s1;
      nxt_out = m_out;
      if (fall_stb) begin
        if (!any) nxt_out = 0;
        else if (mode1) nxt_out = 1;
        else nxt_out = m_s1;
      end
      m_s1 = nxt1;
      m_out = nxt_out;
    end
  end

  task automatic check(input string tag, input logic exp);
    checks++;
    if (ready !== exp) begin
      fails++;
      $display("FAIL %s: ready=%b expected=%b at %0t", tag, ready, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (!done) begin
      string tag;
      if (!rst_n) tag = "R1";
      else if (mode1) tag = "R5";
      else if (m_out) tag = "R3";
      else tag = "R4";
      check(tag, m_out);
    end
    ph = (ph + 1) % 3;
    rise_stb = (ph == 0);
    fall_stb = (ph == 1);
  endtask

  task automatic to_phase(input int p);
    while (ph != p) tick();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: timeout actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic held;
    rise_stb = 1'b1;
    ticks(4);
    check("R1", 1'b0);
    rst_n = 1'b1;

    // R2: disabled bus ignored, enabled bus counts (single-stage)
    mode1 = 1; a_rdy = 1; a_en_n = 1; b_rdy = 0; b_en_n = 0;
    ticks(6);
    check("R2", 1'b0);
    a_en_n = 0;
    ticks(3);
    check("R2", 1'b1);
    a_rdy = 0; a_en_n = 1; b_rdy = 1; b_en_n = 1;
    ticks(3);
    check("R2", 1'b0);

    // R3: two-stage rise needs a rising-edge capture first
    mode1 = 0; b_rdy = 0;
    ticks(3);
    to_phase(1);
    b_en_n = 0; b_rdy = 1;
    tick();
    check("R3", 1'b0);
    ticks(2);
    check("R3", 1'b0);
    tick();
    check("R3", 1'b1);

    // R6: holds between falling strobes
    held = ready;
    b_rdy = 0;
    tick();
    b_rdy = 1;
    tick();
    check("R6", held);

    // R4: drop goes straight through on the falling strobe
    to_phase(1);
    b_rdy = 0;
    tick();
    check("R4", 1'b0);

    // R8: pulse between rising strobes never reaches output
    ticks(3);
    to_phase(1);
    a_en_n = 0; a_rdy = 1;
    ticks(2);
    a_rdy = 0;
    ticks(3);
    check("R8", 1'b0);

    // R7: switch to single stage mid-cycle with empty stage one
    to_phase(1);
    mode1 = 1; a_rdy = 1;
    tick();
    check("R7", 1'b1);
    mode1 = 0;
    ticks(3);
    check("R7", 1'b1);

    // random sweep over enables and modes
    for (int i = 0; i < 600; i++) begin
      a_rdy = $urandom_range(0, 1);
      b_rdy = $urandom_range(0, 1);
      a_en_n = $urandom_range(0, 1);
      b_en_n = $urandom_range(0, 1);
      if ((i % 7) == 0) mode1 = $urandom_range(0, 1);
      tick();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule